// File: doc/BRIEF.md
# Dual-Tone Sine PWM Synthesizer

This block turns two tone frequencies into one audio-rate pulse-width-modulated output bit. Each tone has a phase accumulator with three fractional bits. Once per PWM period, each accumulator is read to form a rounded index into one shared sine table, and then advances by the step width given for that tone. The sample of the lower tone is cut to roughly three quarters of full scale with rounding. The two samples are added, and the sum becomes the duty value of an 8-bit up/down (phase-correct) PWM that repeats every 510 clocks.

A step width is round(8 × 128 × f × 510 / Fclk). With an 8 MHz clock, the four row tones use steps 46, 50, 56 and 61, and the four column tones use steps 79, 87, 96 and 107. Choosing which pair of tones to play, and filtering the PWM bit back into an analog signal, are both handled outside this block. A one-clock strobe marks each period boundary, at which a new duty value takes effect.

Top module: `dual_tone_pwm`

## Requirements
- R1: After reset, `pwmOut` and `sampleStrobe` are low, both accumulators are zero and the active duty value is zero. The first period after enable therefore has no high cycles. The first duty value loaded is 112, because both tones read table entry 0.
- R2: While enabled, `sampleStrobe` is high for exactly one clock once every 510 enabled clocks. The first strobe comes 510 enabled clocks after `enable` rises out of reset.
- R3: A triangle count t runs 0,1,…,255,254,…,1 (510 states). `pwmOut` is high exactly when `enable` is high and t < duty. Over one period this gives 0 high cycles for duty 0 and 2·duty−1 high cycles otherwise.
- R4: At each period boundary, a tone's table index is ((acc mod 4096) + 4) >> 3, taken modulo 128. The index uses the accumulator value from before the boundary. The accumulator then grows by the step width, wrapping modulo 1024 (a wider accumulator masked to 12 bits would give the same index).
- R5: For k < 64, sine table entry k is 64 + round(63·sin(2πk/128)). For k ≥ 64, entry k is 63 + round(63·sin(2πk/128)). The table spans 0..127, with 127 at k = 32 and 0 at k = 96.
- R6: The new duty value is the high-tone sample plus (s − ((s + 2) >> 2)), where s is the low-tone sample. The result never exceeds 222.
- R7: The active duty value changes only at a period boundary. The strobe is high in the first clock that uses the new value.
- R8: A step width of zero leaves that tone's accumulator unchanged at the boundary. With both steps zero, every period after the first fully settled one repeats the same duty value.
- R9: While `enable` is low, the triangle count, both accumulators and the duty value all hold. `pwmOut` and `sampleStrobe` stay low. When `enable` returns, the period resumes where it stopped, so no period boundary is lost or added.
- R10: The step inputs take effect only at a period boundary. A change in the middle of a period sets the increment applied at the next boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the synthesizer; low freezes all state and silences the output |
| stepLow | input | 8 | Phase step width of the lower tone |
| stepHigh | input | 8 | Phase step width of the upper tone |
| pwmOut | output | 1 | PWM output bit |
| sampleStrobe | output | 1 | One-clock pulse at each period boundary |

## Verification
The two functions that can fall in the same cycle are the period-boundary update and an enable drop. Both are provoked by pulling `enable` low on the very clock whose edge would otherwise fire the boundary, and by a second pause in the middle of a period. The run is judged by three results: no strobe and no high output during the pause, a strobe only after `enable` returns with exactly 510 enabled clocks counted, and a high-cycle count for that period that matches the duty value the reference model predicts from its own sine computation.

// File: rtl/dtp_pkg.sv
package dtp_pkg;

  // Table geometry and datapath widths
  localparam int ADDR_W    = 7;   // 128-entry sine table
  localparam int SAMPLE_W  = 7;   // 7-bit samples
  localparam int FRAC_BITS = 3;   // fractional accumulator bits
  localparam int DUTY_W    = 8;   // PWM resolution
  localparam int STEP_W    = 8;   // step width input

  // Strobes and count from control to datapath
  typedef struct packed {
    logic              tick;    // period boundary (last enabled clock of a period)
    logic              run;     // block enabled this clock
    logic [DUTY_W-1:0] triCnt;  // triangle count 0..255..1
  } ctrl_t;

  // Quarter wave: round(63 * sin(pi*k/64)), k = 0..32
  function automatic logic [5:0] quarterSine(input logic [5:0] k);
    logic [5:0] q;
    case (k)
      6'd0:  q = 6'd0;   6'd1:  q = 6'd3;   6'd2:  q = 6'd6;   6'd3:  q = 6'd9;
      6'd4:  q = 6'd12;  6'd5:  q = 6'd15;  6'd6:  q = 6'd18;  6'd7:  q = 6'd21;
      6'd8:  q = 6'd24;  6'd9:  q = 6'd27;  6'd10: q = 6'd30;  6'd11: q = 6'd32;
      6'd12: q = 6'd35;  6'd13: q = 6'd38;  6'd14: q = 6'd40;  6'd15: q = 6'd42;
      6'd16: q = 6'd45;  6'd17: q = 6'd47;  6'd18: q = 6'd49;  6'd19: q = 6'd51;
      6'd20: q = 6'd52;  6'd21: q = 6'd54;  6'd22: q = 6'd56;  6'd23: q = 6'd57;
      6'd24: q = 6'd58;  6'd25: q = 6'd59;  6'd26: q = 6'd60;  6'd27: q = 6'd61;
      6'd28: q = 6'd62;  6'd29: q = 6'd62;  default: q = 6'd63;
    endcase
    return q;
  endfunction

  // Full-period lookup built from the quarter wave by mirroring
  function automatic logic [SAMPLE_W-1:0] sineAt(input logic [ADDR_W-1:0] idx);
    logic [5:0] k;
    logic [5:0] kFold;
    logic [5:0] mag;
    k     = idx[ADDR_W-2:0];
    kFold = (k <= 6'd32) ? k : 6'(7'd64 - {1'b0, k});
    mag   = quarterSine(kFold);
    if (idx[ADDR_W-1]) return SAMPLE_W'(7'd63 - {1'b0, mag});
    else               return SAMPLE_W'(7'd64 + {1'b0, mag});
  endfunction

endpackage

// File: rtl/dtp_ctrl.sv
module dtp_ctrl
  import dtp_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  enable,
  output ctrl_t ctrl
);

  localparam int TOP    = (1 << DUTY_W) - 1;   // 255
  localparam int PERIOD = 2 * TOP;             // 510 clocks
  localparam int PH_W   = $clog2(PERIOD);

  logic [PH_W-1:0] phase;
  logic            lastPhase;

  assign lastPhase = (phase == PH_W'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rstN)          phase <= '0;
    else if (enable)    phase <= lastPhase ? '0 : phase + 1'b1;
  end

  always_comb begin
    ctrl.run    = enable;
    ctrl.tick   = enable && lastPhase;
    ctrl.triCnt = (phase <= PH_W'(TOP)) ? DUTY_W'(phase)
                                        : DUTY_W'(PH_W'(PERIOD) - phase);
  end

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rstN) phase < PH_W'(PERIOD)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN) !enable |=> $stable(phase)); // R9
  AST_TRI_BOTTOM: assert property (@(posedge clk) disable iff (!rstN) ctrl.tick |=> (ctrl.triCnt == '0)); // R3

endmodule

// File: rtl/dtp_tone.sv
module dtp_tone
  import dtp_pkg::*;
#(
  parameter int STEP_WIDTH = STEP_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tick,
  input  logic [STEP_WIDTH-1:0] step,
  output logic [SAMPLE_W-1:0]   sample
);

  localparam int ACC_W     = ADDR_W + FRAC_BITS;   // index only sees these bits
  localparam int ROUND_ADD = 1 << (FRAC_BITS - 1);

  logic [ACC_W-1:0]  acc;
  logic [ADDR_W-1:0] index;

  // Rounded index from the pre-increment phase
  assign index  = ADDR_W'((acc + ACC_W'(ROUND_ADD)) >> FRAC_BITS);
  assign sample = sineAt(index);

  always_ff @(posedge clk) begin
    if (!rstN)     acc <= '0;
    else if (tick) acc <= acc + ACC_W'(step);
  end

  AST_ZERO_STEP_FREEZE: assert property (@(posedge clk) disable iff (!rstN) (tick && step == '0) |=> $stable(acc)); // R8
  AST_ACC_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rstN) !tick |=> $stable(acc)); // R10

endmodule

// File: rtl/dtp_datapath.sv
module dtp_datapath
  import dtp_pkg::*;
#(
  parameter int STEP_WIDTH = STEP_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrl_t                 ctrl,
  input  logic [STEP_WIDTH-1:0] stepLow,
  input  logic [STEP_WIDTH-1:0] stepHigh,
  output logic                  pwmOut,
  output logic                  sampleStrobe
);

  localparam int NUM_TONES = 2;
  localparam int LOW_IDX   = 0;
  localparam int MAX_S     = (1 << SAMPLE_W) - 1;
  localparam int MIX_MAX   = MAX_S + MAX_S - ((MAX_S + 2) >> 2);

  logic [STEP_WIDTH-1:0] steps  [NUM_TONES];
  logic [SAMPLE_W-1:0]   raw    [NUM_TONES];
  logic [DUTY_W-1:0]     shaped [NUM_TONES];
  logic [DUTY_W-1:0]     mixSum;
  logic [DUTY_W-1:0]     dutyActive;

  assign steps[0] = stepLow;
  assign steps[1] = stepHigh;

  for (genvar g = 0; g < NUM_TONES; g++) begin : g_tone
    dtp_tone #(.STEP_WIDTH(STEP_WIDTH)) u_tone (
      .clk    (clk),
      .rstN   (rstN),
      .tick   (ctrl.tick),
      .step   (steps[g]),
      .sample (raw[g])
    );
    if (g == LOW_IDX) begin : g_atten
      // s - round(s/4): about three quarters
      assign shaped[g] = DUTY_W'(raw[g]) - ((DUTY_W'(raw[g]) + DUTY_W'(2)) >> 2);
    end else begin : g_full
      assign shaped[g] = DUTY_W'(raw[g]);
    end
  end

  assign mixSum = shaped[0] + shaped[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dutyActive   <= '0;
      sampleStrobe <= 1'b0;
    end else begin
      sampleStrobe <= ctrl.tick;
      if (ctrl.tick) dutyActive <= mixSum;
    end
  end

  assign pwmOut = ctrl.run && (ctrl.triCnt < dutyActive);

  AST_DUTY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN) !ctrl.tick |=> $stable(dutyActive)); // R7
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rstN) sampleStrobe |=> !sampleStrobe); // R2
  AST_MIX_CEILING: assert property (@(posedge clk) disable iff (!rstN) dutyActive <= DUTY_W'(MIX_MAX)); // R6
  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN) !ctrl.run |=> !sampleStrobe); // R9

endmodule

// File: rtl/dual_tone_pwm.sv
module dual_tone_pwm
  import dtp_pkg::*;
#(
  parameter int STEP_WIDTH = STEP_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  enable,
  input  logic [STEP_WIDTH-1:0] stepLow,
  input  logic [STEP_WIDTH-1:0] stepHigh,
  output logic                  pwmOut,
  output logic                  sampleStrobe
);

  ctrl_t ctrl;

  dtp_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .ctrl   (ctrl)
  );

  dtp_datapath #(.STEP_WIDTH(STEP_WIDTH)) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .stepLow      (stepLow),
    .stepHigh     (stepHigh),
    .pwmOut       (pwmOut),
    .sampleStrobe (sampleStrobe)
  );

  AST_PWM_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rstN) !enable |-> !pwmOut); // R9

endmodule

// File: tb/dual_tone_pwm_tb.sv
module dual_tone_pwm_tb;

  localparam int CLK_PERIOD  = 10;
  localparam int PERIOD_CLKS = 510;
  localparam int NUM_VECS    = 8;
  // {stepLow, stepHigh, periods}
  localparam logic [23:0] VECS [NUM_VECS] = '{
    {8'd46,  8'd79,  8'd4},
    {8'd61,  8'd107, 8'd4},
    {8'd3,   8'd4,   8'd3},
    {8'd50,  8'd96,  8'd3},
    {8'd0,   8'd87,  8'd3},
    {8'd56,  8'd0,   8'd3},
    {8'd0,   8'd0,   8'd3},
    {8'd255, 8'd255, 8'd4}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [7:0] stepLow = '0;
  logic [7:0] stepHigh = '0;
  wire        pwmOut;
  wire        sampleStrobe;

  int checks = 0;
  int errors = 0;
  int mAccL = 0;
  int mAccH = 0;
  int mDuty = 0;
  int sineRef [128];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_tone_pwm u_dut (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .stepLow      (stepLow),
    .stepHigh     (stepHigh),
    .pwmOut       (pwmOut),
    .sampleStrobe (sampleStrobe)
  );

  function automatic int refIndex(int acc);
    return (((acc & 4095) + 4) >> 3) & 127;
  endfunction

  function automatic int refHighCount(int duty);
    return (duty == 0) ? 0 : 2 * duty - 1;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic modelTick();
    int sl;
    int sh;
    sl    = sineRef[refIndex(mAccL)];
    sh    = sineRef[refIndex(mAccH)];
    mDuty = sh + sl - ((sl + 2) >> 2);
    mAccL = (mAccL + int'(stepLow)) & 65535;
    mAccH = (mAccH + int'(stepHigh)) & 65535;
  endtask

  // Walk one period from a strobe (or enable) clock to the next strobe.
  task automatic runPeriod(input int pauseAt, input int pauseLen,
                           output int highCnt, output int len, output int bad);
    highCnt = 0;
    len = 0;
    bad = 0;
    while (1) begin
      highCnt += int'(pwmOut);
      len++;
      if (pauseLen > 0 && len == pauseAt) begin
        enable = 1'b0;
        for (int i = 0; i < pauseLen; i++) begin
          @(negedge clk);
          if (pwmOut || sampleStrobe) bad++;
        end
        enable = 1'b1;
      end
      @(negedge clk);
      if (sampleStrobe || len >= 600) break;
    end
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
    finishRun();
  end

  initial begin
    int hi;
    int len;
    int bad;
    int prevHi;

    for (int i = 0; i < 128; i++) begin
      real v;
      v = 63.0 * $sin(2.0 * 3.14159265358979 * real'(i) / 128.0);
      sineRef[i] = (i < 64 ? 64 : 63) + int'(v);
    end

    // R1: reset state
    repeat (3) @(negedge clk);
    check(pwmOut == 1'b0, "R1 pwm low in reset", int'(pwmOut), 0);
    check(sampleStrobe == 1'b0, "R1 strobe low in reset", int'(sampleStrobe), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R9: disabled after reset, no strobe and no output
    bad = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (pwmOut || sampleStrobe) bad++;
    end
    check(bad == 0, "R9 idle output", bad, 0);

    // R1/R2: first period after enable is silent and 510 clocks long
    stepLow  = VECS[0][23:16];
    stepHigh = VECS[0][15:8];
    enable   = 1'b1;
    runPeriod(0, 0, hi, len, bad);
    check(len == PERIOD_CLKS, "R2 first strobe spacing", len, PERIOD_CLKS);
    check(hi == 0, "R1 first period silent", hi, 0);
    modelTick();
    check(mDuty == 112, "R1/R5/R6 model first duty", mDuty, 112);

    // Vector walk: R3 R4 R5 R6 R7 R8 R10
    prevHi = -1;
    for (int v = 0; v < NUM_VECS; v++) begin
      stepLow  = VECS[v][23:16];
      stepHigh = VECS[v][15:8];
      for (int p = 0; p < int'(VECS[v][7:0]); p++) begin
        runPeriod(0, 0, hi, len, bad);
        check(len == PERIOD_CLKS, "R2 strobe spacing", len, PERIOD_CLKS);
        check(hi == refHighCount(mDuty), "R3/R4/R5/R6/R10 duty high count", hi, refHighCount(mDuty));
        if (VECS[v][23:16] == 8'd0 && VECS[v][15:8] == 8'd0 && p >= 2)
          check(hi == prevHi, "R8 frozen tones repeat duty", hi, prevHi);
        prevHi = hi;
        modelTick();
      end
    end

    // R9: pause in the middle of a period
    stepLow  = 8'd46;
    stepHigh = 8'd79;
    runPeriod(200, 100, hi, len, bad);
    check(bad == 0, "R9 mid-period pause quiet", bad, 0);
    check(len == PERIOD_CLKS, "R9 mid-period pause length", len, PERIOD_CLKS);
    check(hi == refHighCount(mDuty), "R9/R7 paused duty", hi, refHighCount(mDuty));
    modelTick();

    // R9/R7: pause on the boundary clock itself
    runPeriod(PERIOD_CLKS, 50, hi, len, bad);
    check(bad == 0, "R9 boundary pause quiet", bad, 0);
    check(len == PERIOD_CLKS, "R9 boundary pause length", len, PERIOD_CLKS);
    check(hi == refHighCount(mDuty), "R7 boundary pause duty", hi, refHighCount(mDuty));
    modelTick();
    runPeriod(0, 0, hi, len, bad);
    check(hi == refHighCount(mDuty), "R7 duty after boundary pause", hi, refHighCount(mDuty));
    modelTick();

    // R1: reset in mid-run clears phase, accumulators and duty
    repeat (123) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(pwmOut == 1'b0 && sampleStrobe == 1'b0, "R1 outputs after mid-run reset",
          int'(pwmOut) + int'(sampleStrobe), 0);
    rstN = 1'b1;
    mAccL = 0;
    mAccH = 0;
    mDuty = 0;
    runPeriod(0, 0, hi, len, bad);
    check(len == PERIOD_CLKS, "R1/R2 period after reset", len, PERIOD_CLKS);
    check(hi == 0, "R1 duty zero after reset", hi, 0);
    modelTick();
    runPeriod(0, 0, hi, len, bad);
    check(hi == refHighCount(112), "R1 first loaded duty 112", hi, refHighCount(112));

    finishRun();
  end

endmodule